// File: doc/BRIEF.md
# Four-Phase Register/ALU Sequencer

This block runs a small register-and-ALU datapath through an instruction cycle split into four strictly ordered phases. A one-hot phase ring advances on every clock. Each phase strobe gates the load enables of one group of storage elements, so every element updates only after the values it depends on have settled. The datapath holds eight 16-bit general registers, two operand buffers (A and B), an ALU with a registered zero flag, an instruction register, an address register and a data register for outgoing memory writes.

The cycle runs as follows. In phase 1 the instruction register latches the word on `instr_i`. In phase 2 the operand buffers copy the two registers that the instruction selects. In phase 3 the address register may take the B operand, and the zero flag captures the ALU outcome. In phase 4 the ALU result goes to a destination register, to the data register for a memory write, or to both. Phase 1 of the next instruction follows at once.

The instruction source and the memory side have no back-pressure. The instruction word only has to be valid during the phase-1 cycle. The memory write request is a one-cycle strobe with no ready, and the address and data it refers to stay stable while it is high. The current phase and every gated load enable are brought out so that the ordering can be observed.

Top module: `phseq_top`

## Requirements
- R1: `phase_o` is one-hot and steps 4'b0001 → 4'b0010 → 4'b0100 → 4'b1000 → 4'b0001 on consecutive clocks, with no idle cycle between instruction cycles.
- R2: The instruction register loads `instr_i` only at the end of phase 1 and holds it through phases 2 to 4. The field layout is: bits [2:0] ALU op, [5:3] source A select, [8:6] source B select, [11:9] destination select, bit 12 address-load flag, bit 13 register-write flag, bit 14 memory-write flag, bit 15 spare.
- R3: The A and B buffers capture the registers named by the source A and source B selects only at the end of phase 2, and hold otherwise.
- R4: At the end of phase 3 the address register takes the B buffer when bit 12 is set. Otherwise it keeps its value.
- R5: ALU op codes: 0 add, 1 subtract (A−B), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 pass B, 7 A+1. All arithmetic wraps modulo 2^16.
- R6: The zero flag is loaded at the end of phase 3 with (ALU result == 0) and holds for the rest of the cycle.
- R7: At the end of phase 4, when bit 13 is set, the ALU result is written to the destination register (register 0 included). A write to a register that is also a source leaves the buffers of the current cycle unchanged.
- R8: At the end of phase 4, when bit 14 is set, the data register takes the ALU result. `mem_we_o` is then high for exactly the one following cycle (phase 1). Register write and memory write may both happen in the same phase 4.
- R9: A synchronous active-high reset sets `phase_o` to 4'b0001 and clears the instruction register, the buffers, the address and data registers, the zero flag, `mem_we_o` and every general register.
- R10: Each load-enable output is high only in its own phase: `ir_ld_o` in phase 1, `ab_ld_o` in phase 2, `mar_ld_o` and `zf_ld_o` in phase 3, `rf_we_o` and `mdr_ld_o` in phase 4. Those that are gated by a flag are also high only when their flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word, sampled in phase 1 |
| phase_o | output | 4 | One-hot current phase |
| ir_ld_o | output | 1 | Instruction register load enable |
| ab_ld_o | output | 1 | Operand buffer load enable |
| mar_ld_o | output | 1 | Address register load enable |
| zf_ld_o | output | 1 | Zero flag load enable |
| rf_we_o | output | 1 | Register file write enable |
| mdr_ld_o | output | 1 | Data register load enable |
| ir_o | output | 16 | Instruction register contents |
| a_buf_o | output | 16 | A operand buffer |
| b_buf_o | output | 16 | B operand buffer |
| alu_y_o | output | 16 | Combinational ALU result |
| zero_o | output | 1 | Registered zero flag |
| mar_o | output | 16 | Memory address register |
| mdr_o | output | 16 | Memory data register |
| mem_we_o | output | 1 | One-cycle memory write request |

## Verification
Each result falls due one clock edge after the phase that loads it. The instruction register changes at the edge that ends phase 1 and the buffers at the edge that ends phase 2. The address register and zero flag change at the edge that ends phase 3, and the register file and data register at the edge that ends phase 4. The write request is high during the next phase 1. The bench model advances the same phase count at each rising edge from the requirements alone. Outputs are compared at every falling edge, so each value is checked in the first cycle it is due and in every cycle it must hold. Register contents are brought out by pass-A instructions that end in a memory write.

// File: rtl/phseq_pkg.sv
package phseq_pkg;
  localparam int SEL_W   = 3;
  localparam int NREG    = 1 << SEL_W;
  localparam int INSTR_W = 16;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PA   = 3'd5,
    ALU_PB   = 3'd6,
    ALU_INCA = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic             spare;
    logic             mem_wr;
    logic             reg_wr;
    logic             addr_ld;
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] src_a;
    alu_op_e          op;
  } instr_t;
endpackage

// File: rtl/phseq_ring.sv
module phseq_ring #(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NPH-1:0] phase_o
);
  logic [NPH-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst) ring_q <= NPH'(1);
    else     ring_q <= {ring_q[NPH-2:0], ring_q[NPH-1]};
  end

  assign phase_o = ring_q;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    ring_q[NPH-1] |=> ring_q[0]); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    ring_q[0] |=> ring_q[1]); // R1
endmodule

// File: rtl/phseq_regfile.sv
module phseq_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel_a,
  input  logic [SEL_W-1:0]  rsel_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int NREG = 1 << SEL_W;

  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                            regs_q[i] <= '0;
      else if (we && wsel == SEL_W'(i))   regs_q[i] <= wdata;
    end
  end

  assign rdata_a = regs_q[rsel_a];
  assign rdata_b = regs_q[rsel_b];
endmodule

// File: rtl/phseq_alu.sv
module phseq_alu
  import phseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              is_zero
);
  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_PA:   y = a;
      ALU_PB:   y = b;
      default:  y = a + DATA_W'(1);
    endcase
  end

  assign is_zero = (y == '0);
endmodule

// File: rtl/phseq_top.sv
module phseq_top
  import phseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [3:0]         phase_o,
  output logic               ir_ld_o,
  output logic               ab_ld_o,
  output logic               mar_ld_o,
  output logic               zf_ld_o,
  output logic               rf_we_o,
  output logic               mdr_ld_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic [DATA_W-1:0]  a_buf_o,
  output logic [DATA_W-1:0]  b_buf_o,
  output logic [DATA_W-1:0]  alu_y_o,
  output logic               zero_o,
  output logic [DATA_W-1:0]  mar_o,
  output logic [DATA_W-1:0]  mdr_o,
  output logic               mem_we_o
);
  localparam int NPH = 4;

  logic [NPH-1:0]    ph;
  instr_t            ir_q;
  logic [DATA_W-1:0] a_q, b_q, mar_q, mdr_q, rd_a, rd_b, alu_y;
  logic              zf_q, alu_zero, mem_we_q;
  logic              ir_ld, ab_ld, mar_ld, zf_ld, rf_we, mdr_ld;

  phseq_ring #(.NPH(NPH)) u_ring (
    .clk(clk), .rst(rst), .phase_o(ph)
  );

  // phase-gated load enables
  assign ir_ld  = ph[0];
  assign ab_ld  = ph[1];
  assign mar_ld = ph[2] & ir_q.addr_ld;
  assign zf_ld  = ph[2];
  assign rf_we  = ph[3] & ir_q.reg_wr;
  assign mdr_ld = ph[3] & ir_q.mem_wr;

  phseq_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wsel(ir_q.dst), .wdata(alu_y),
    .rsel_a(ir_q.src_a), .rsel_b(ir_q.src_b), .rdata_a(rd_a), .rdata_b(rd_b)
  );

  phseq_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ir_q.op), .a(a_q), .b(b_q), .y(alu_y), .is_zero(alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      mar_q    <= '0;
      mdr_q    <= '0;
      zf_q     <= 1'b0;
      mem_we_q <= 1'b0;
    end else begin
      if (ir_ld)  ir_q  <= instr_t'(instr_i);
      if (ab_ld) begin
        a_q <= rd_a;
        b_q <= rd_b;
      end
      if (mar_ld) mar_q <= b_q;
      if (zf_ld)  zf_q  <= alu_zero;
      if (mdr_ld) mdr_q <= alu_y;
      mem_we_q <= mdr_ld;
    end
  end

  assign phase_o  = ph;
  assign ir_ld_o  = ir_ld;
  assign ab_ld_o  = ab_ld;
  assign mar_ld_o = mar_ld;
  assign zf_ld_o  = zf_ld;
  assign rf_we_o  = rf_we;
  assign mdr_ld_o = mdr_ld;
  assign ir_o     = ir_q;
  assign a_buf_o  = a_q;
  assign b_buf_o  = b_q;
  assign alu_y_o  = alu_y;
  assign zero_o   = zf_q;
  assign mar_o    = mar_q;
  assign mdr_o    = mdr_q;
  assign mem_we_o = mem_we_q;

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph[0] |=> $stable(ir_q)); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph[1] |=> ($stable(a_q) && $stable(b_q))); // R3
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph[2] |=> $stable(mar_q)); // R4
  AST_ZF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph[2] |=> $stable(zf_q)); // R6
  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ph[3] |=> $stable(mdr_q)); // R8
  AST_MEMWE_ONE: assert property (@(posedge clk) disable iff (rst)
    mem_we_q |=> !mem_we_q); // R8
  AST_MEMWE_PH1: assert property (@(posedge clk) disable iff (rst)
    mem_we_q |-> ph[0]); // R8
endmodule

// File: tb/phseq_top_tb.sv
`timescale 1ns/1ps
module phseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_i = '0;
  logic [3:0]  phase_o;
  logic        ir_ld_o, ab_ld_o, mar_ld_o, zf_ld_o, rf_we_o, mdr_ld_o;
  logic [15:0] ir_o, a_buf_o, b_buf_o, alu_y_o, mar_o, mdr_o;
  logic        zero_o, mem_we_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit started = 0;

  always #2 clk = ~clk;

  phseq_top dut_i (
    .clk(clk), .rst(rst), .instr_i(instr_i), .phase_o(phase_o),
    .ir_ld_o(ir_ld_o), .ab_ld_o(ab_ld_o), .mar_ld_o(mar_ld_o),
    .zf_ld_o(zf_ld_o), .rf_we_o(rf_we_o), .mdr_ld_o(mdr_ld_o),
    .ir_o(ir_o), .a_buf_o(a_buf_o), .b_buf_o(b_buf_o), .alu_y_o(alu_y_o),
    .zero_o(zero_o), .mar_o(mar_o), .mdr_o(mdr_o), .mem_we_o(mem_we_o)
  );

  // behavioural reference model
  int m_ph;
  int m_ir, m_a, m_b, m_mar, m_mdr, m_z, m_we;
  int m_rf [8];

  function automatic int ref_alu(int op, int a, int b);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a;
      6: r = b;
      default: r = a + 1;
    endcase
    return r & 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_ph = 0; m_ir = 0; m_a = 0; m_b = 0; m_mar = 0; m_mdr = 0; m_z = 0; m_we = 0;
      for (int i = 0; i < 8; i++) m_rf[i] = 0;
    end else begin
      int y;
      y = ref_alu(m_ir & 7, m_a, m_b);
      m_we = 0;
      case (m_ph)
        0: m_ir = int'(instr_i);
        1: begin m_a = m_rf[(m_ir >> 3) & 7]; m_b = m_rf[(m_ir >> 6) & 7]; end
        2: begin
          if (m_ir[12]) m_mar = m_b;
          m_z = (y == 0) ? 1 : 0;
        end
        default: begin
          if (m_ir[13]) m_rf[(m_ir >> 9) & 7] = y;
          if (m_ir[14]) begin m_mdr = y; m_we = 1; end
        end
      endcase
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(rst ? "R9" : "R1", "phase", int'(phase_o), 1 << m_ph);
      chk("R10", "ir_ld",  int'(ir_ld_o),  (m_ph == 0) ? 1 : 0);
      chk("R10", "ab_ld",  int'(ab_ld_o),  (m_ph == 1) ? 1 : 0);
      chk("R10", "mar_ld", int'(mar_ld_o), (m_ph == 2 && m_ir[12]) ? 1 : 0);
      chk("R10", "zf_ld",  int'(zf_ld_o),  (m_ph == 2) ? 1 : 0);
      chk("R10", "rf_we",  int'(rf_we_o),  (m_ph == 3 && m_ir[13]) ? 1 : 0);
      chk("R10", "mdr_ld", int'(mdr_ld_o), (m_ph == 3 && m_ir[14]) ? 1 : 0);
      chk("R2", "ir",    int'(ir_o),    m_ir);
      chk("R3", "a_buf", int'(a_buf_o), m_a);
      chk("R3", "b_buf", int'(b_buf_o), m_b);
      chk("R4", "mar",   int'(mar_o),   m_mar);
      chk("R6", "zero",  int'(zero_o),  m_z);
      chk("R8", "mdr",   int'(mdr_o),   m_mdr);
      chk("R8", "mem_we", int'(mem_we_o), m_we);
      if (m_ph == 3) chk("R5", "alu_y", int'(alu_y_o), ref_alu(m_ir & 7, m_a, m_b));
    end
  end

  // encode: op, srcA, srcB, dst, addr_ld, reg_wr, mem_wr
  function automatic logic [15:0] enc(int op, int sa, int sb, int d, bit al, bit rw, bit mw);
    return {1'b0, mw, rw, al, 3'(d), 3'(sb), 3'(sa), 3'(op)};
  endfunction

  task automatic run(logic [15:0] w);
    instr_i = w;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run(enc(7, 0, 0, 1, 0, 1, 0));   // r1 = 1   (R5 inc, R7)
    run(enc(0, 1, 1, 2, 0, 1, 0));   // r2 = 2   (R5 add)
    run(enc(7, 2, 0, 3, 0, 1, 0));   // r3 = 3
    run(enc(1, 3, 3, 4, 0, 1, 1));   // r4 = 0, zero flag, reg+mem write (R6, R8)
    run(enc(1, 0, 1, 5, 1, 1, 0));   // r5 = FFFF wrap, mar = r1 (R4, R5)
    run(enc(4, 5, 2, 6, 0, 1, 1));   // xor
    run(enc(2, 5, 3, 7, 0, 1, 0));   // and
    run(enc(3, 2, 1, 0, 0, 1, 0));   // or into r0 (R7)
    run(enc(6, 0, 5, 5, 1, 0, 1));   // pass B, mem only (R8)
    run(enc(7, 3, 3, 3, 0, 1, 0));   // dst == src (R7)
    for (int r = 0; r < 8; r++) run(enc(5, r, 0, 0, 0, 0, 1)); // read back via MDR
    for (int k = 0; k < 200; k++) run(16'($urandom));
    @(negedge clk); rst = 1'b1;          // mid-run reset (R9)
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 8; r++) run(enc(5, r, 0, 0, 1, 0, 1)); // all cleared (R9)
    for (int k = 0; k < 100; k++) run(16'($urandom));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule